// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Two-Entry Buffer

This block turns an asynchronous serial line back into characters. A sample strobe from a separate baud-rate generator ticks OVS times per bit. The block synchronises the line and waits for a falling edge. It confirms the start bit at mid-bit and takes three consecutive samples around the middle of every bit. The majority of those three samples becomes the bit value. The block checks the optional parity bit and the first stop bit. Each result is then written into a two-entry receive buffer.

Each buffer entry holds up to nine data bits and three flags: parity error, framing error and overrun. The outputs always present the oldest entry. A one-cycle read strobe removes that entry. Software therefore reads the ninth bit and the flags before it issues the read that pops the data.

For links shared by several receivers, a filtering mode is available. A frame whose ninth bit is 1 carries an address. Data frames are thrown away unless the most recent address frame matched the block's own address.

Top module: `serial_rx`

## Requirements
- R1: After synchronous reset the buffer is empty. `rx_avail`, `par_err`, `frm_err` and `ovr_err` are all 0.
- R2: A frame is one low start bit, then `rx_bits` data bits (5 to 9; values outside the range are clamped), then an optional parity bit, then a high stop bit. Data arrives LSB first and is stored at bit positions 0 upward. Data bits that were not received read back as 0. `rd_bit9` shows data bit 8.
- R3: The value of every bit is the majority of three line samples. These are taken on sample ticks OVS/2-1, OVS/2 and OVS/2+1 of that bit. A one-tick glitch inside a bit therefore does not change the stored value.
- R4: A falling edge counts as a start bit only when the majority of the mid-bit samples is low. A low pulse that is already high again by mid-bit stores nothing.
- R5: `par_mode` selects the parity: 2'b00 or 2'b01 means no parity bit, 2'b10 means even, 2'b11 means odd. The entry's parity-error flag is set when the data bits together with the received parity bit do not give the selected parity. Without parity the flag is always 0.
- R6: The framing-error flag of an entry is set when the majority value of its first stop bit is 0.
- R7: The buffer holds two entries in arrival order. `rx_avail` is high while at least one entry is unread. The data, ninth bit and flags shown all belong to the oldest entry. A `rd_pop` pulse removes that entry, and a pop on an empty buffer has no effect.
- R8: A frame that completes while both entries are full, with no pop in that cycle, is lost. The overrun flag of the newer stored entry is set, and the older entry is unchanged.
- R9: With `mpc_en` high, an address frame (data bit 8 = 1) is always stored. It enables data reception when its low eight bits equal `own_addr` and disables it otherwise. A data frame (bit 8 = 0) is stored only while reception is enabled. After reset reception is disabled.
- R10: With `rx_en` low the receiver stays idle. The buffer is emptied and the address match is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| samp_tick | input | 1 | Oversampling strobe, OVS per bit |
| rx_line | input | 1 | Serial line, idle high |
| rx_bits | input | 4 | Number of data bits, 5..9 |
| par_mode | input | 2 | Parity selection |
| mpc_en | input | 1 | Address filtering enable |
| own_addr | input | 8 | Address of this receiver |
| rd_pop | input | 1 | Removes the oldest entry |
| rd_data | output | 8 | Data bits 7..0 of the oldest entry |
| rd_bit9 | output | 1 | Data bit 8 of the oldest entry |
| rx_avail | output | 1 | Unread data present |
| frm_err | output | 1 | Framing error of the oldest entry |
| par_err | output | 1 | Parity error of the oldest entry |
| ovr_err | output | 1 | Overrun flag of the oldest entry |

## Verification
The bench holds the sample tick high, so one bit lasts 16 cycles. After the two synchroniser stages and the start-detect register, a bit's three votes fall 8 to 10 cycles after the line changes. A frame's entry therefore becomes visible about 11 cycles into its stop bit. Every frame is followed by at least one idle bit, and outputs are only sampled on falling edges after that idle period, so no check waits on a frame still in flight. After a pop, the next entry is visible from the edge that takes the pop onward, and it is read at the following falling edge.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int MAX_BITS = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                perr;
        logic                ferr;
        logic                ovr;
    } rx_entry_t;

    function automatic logic [3:0] clamp_bits(input logic [3:0] req);
        if (req < 4'd5) return 4'd5;
        if (req > 4'd9) return 4'd9;
        return req;
    endfunction

    function automatic logic majority3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import serial_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_en,
    input  logic      tick,
    input  logic      line_s,
    input  logic [3:0] nbits,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      frame_vld,
    output rx_entry_t frame
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] S0_AT  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] S1_AT  = CW'(OVS / 2);
    localparam logic [CW-1:0] VOTE_AT = CW'(OVS / 2 + 1);
    localparam logic [CW-1:0] END_AT = CW'(OVS - 1);

    rx_state_e           state;
    logic [CW-1:0]       cnt;
    logic [3:0]          bidx;
    logic                s0, s1, acc, perr;
    logic [MAX_BITS-1:0] shreg;
    logic                vote;

    assign vote = majority3(s0, s1, line_s);

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bidx      <= '0;
            s0        <= 1'b1;
            s1        <= 1'b1;
            acc       <= 1'b0;
            perr      <= 1'b0;
            shreg     <= '0;
            frame_vld <= 1'b0;
            frame     <= '0;
        end else begin
            frame_vld <= 1'b0;
            if (state == ST_IDLE) begin
                cnt   <= '0;
                bidx  <= '0;
                acc   <= 1'b0;
                perr  <= 1'b0;
                shreg <= '0;
                if (tick && !line_s) state <= ST_START;
            end else if (tick) begin
                cnt <= (cnt == END_AT) ? '0 : cnt + 1'b1;
                if (cnt == S0_AT) s0 <= line_s;
                if (cnt == S1_AT) s1 <= line_s;
                if (cnt == VOTE_AT) begin
                    case (state)
                        ST_START: if (vote) state <= ST_IDLE;
                        ST_DATA: begin
                            shreg[bidx] <= vote;
                            acc         <= acc ^ vote;
                        end
                        ST_PAR:  perr <= acc ^ vote ^ par_odd;
                        ST_STOP: begin
                            frame_vld <= 1'b1;
                            frame     <= '{data: shreg, perr: perr, ferr: !vote, ovr: 1'b0};
                            state     <= ST_IDLE;
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
                if (cnt == END_AT) begin
                    case (state)
                        ST_START: begin
                            state <= ST_DATA;
                            bidx  <= '0;
                        end
                        ST_DATA: begin
                            if (bidx == nbits - 4'd1) begin
                                state <= par_en ? ST_PAR : ST_STOP;
                                bidx  <= '0;
                            end else begin
                                bidx <= bidx + 4'd1;
                            end
                        end
                        ST_PAR:  state <= ST_STOP;
                        default: ;
                    endcase
                end
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_vld |=> !frame_vld); // R2

    AST_NO_PERR_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && !par_en) |-> !frame.perr); // R5

    AST_STOP_FROM_IDLE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && $past(state) == ST_IDLE && !$past(rst)) |-> !frame_vld); // R4
endmodule

// File: rtl/rx_fifo2.sv
module rx_fifo2
    import serial_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       push,
    input  rx_entry_t  wdata,
    input  logic       pop,
    output rx_entry_t  head,
    output logic [1:0] level
);
    rx_entry_t  slot0, slot1;
    logic [1:0] cnt;
    logic       pop_eff, room;
    logic [1:0] widx;

    assign pop_eff = pop && (cnt != 2'd0);
    assign widx    = cnt - {1'b0, pop_eff};
    assign room    = (widx < 2'd2);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cnt   <= '0;
            slot0 <= '0;
            slot1 <= '0;
        end else begin
            if (pop_eff) slot0 <= slot1;
            if (push && room) begin
                if (widx == 2'd0) slot0 <= wdata;
                else              slot1 <= wdata;
            end else if (push) begin
                slot1.ovr <= 1'b1;
            end
            cnt <= cnt + {1'b0, push && room} - {1'b0, pop_eff};
        end
    end

    assign head  = slot0;
    assign level = cnt;

    AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (rst)
        level <= 2'd2); // R7

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst || flush)
        (pop && cnt == 2'd0 && !push) |=> (cnt == 2'd0)); // R7

    AST_FULL_KEEPS_HEAD: assert property (@(posedge clk) disable iff (rst || flush)
        (push && cnt == 2'd2 && !pop) |=> (cnt == 2'd2 && $stable(slot0) && slot1.ovr)); // R8
endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_rx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       samp_tick,
    input  logic       rx_line,
    input  logic [3:0] rx_bits,
    input  logic [1:0] par_mode,
    input  logic       mpc_en,
    input  logic [7:0] own_addr,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    output logic       rd_bit9,
    output logic       rx_avail,
    output logic       frm_err,
    output logic       par_err,
    output logic       ovr_err
);
    logic       line_s, fr_vld, listen, keep;
    rx_entry_t  fr, head;
    logic [1:0] level;

    rx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst(rst), .din(rx_line), .dout(line_s)
    );

    rx_framer #(.OVS(OVS)) u_framer (
        .clk(clk), .rst(rst), .rx_en(rx_en), .tick(samp_tick), .line_s(line_s),
        .nbits(clamp_bits(rx_bits)), .par_en(par_mode[1]), .par_odd(par_mode[0]),
        .frame_vld(fr_vld), .frame(fr)
    );

    assign keep = fr_vld && (!mpc_en || fr.data[8] || listen);

    always_ff @(posedge clk) begin
        if (rst || !rx_en) listen <= 1'b0;
        else if (fr_vld && mpc_en && fr.data[8]) listen <= (fr.data[7:0] == own_addr);
    end

    rx_fifo2 u_fifo (
        .clk(clk), .rst(rst), .flush(!rx_en), .push(keep), .wdata(fr),
        .pop(rd_pop), .head(head), .level(level)
    );

    assign rx_avail = (level != 2'd0);
    assign rd_data  = head.data[7:0];
    assign rd_bit9  = head.data[8];
    assign par_err  = rx_avail && head.perr;
    assign frm_err  = rx_avail && head.ferr;
    assign ovr_err  = rx_avail && head.ovr;

    AST_AVAIL_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_avail) |-> ($past(rd_pop) || !$past(rx_en))); // R7

    AST_MPC_DROP: assert property (@(posedge clk) disable iff (rst || !rx_en)
        (fr_vld && mpc_en && !fr.data[8] && !listen) |=> ($stable(level) || $past(rd_pop))); // R9

    AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !rx_avail); // R10
endmodule

// File: tb/serial_rx_bench.sv
module serial_rx_bench;
    import serial_rx_pkg::*;

    localparam int BITLEN = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b1;
    logic       samp_tick = 1'b1;
    logic       rx_line = 1'b1;
    logic [3:0] rx_bits = 4'd8;
    logic [1:0] par_mode = 2'b00;
    logic       mpc_en = 1'b0;
    logic [7:0] own_addr = 8'h42;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit9, rx_avail, frm_err, par_err, ovr_err;

    int checks = 0;
    int errors = 0;
    rx_entry_t mq[$];
    logic listen_m = 1'b0;

    always #2 clk = ~clk;

    serial_rx u_serial_rx (
        .clk(clk), .rst(rst), .rx_en(rx_en), .samp_tick(samp_tick), .rx_line(rx_line),
        .rx_bits(rx_bits), .par_mode(par_mode), .mpc_en(mpc_en), .own_addr(own_addr),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_bit9(rd_bit9), .rx_avail(rx_avail),
        .frm_err(frm_err), .par_err(par_err), .ovr_err(ovr_err)
    );

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %03h expected %03h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] mask_bits(input logic [8:0] d, input int nb);
        return d & 9'((1 << nb) - 1);
    endfunction

    function automatic rx_entry_t expect_entry(input logic [8:0] d, input int nb,
                                               input logic [1:0] pm, input logic bad_par,
                                               input logic bad_stop);
        rx_entry_t e;
        e.data = mask_bits(d, nb);
        e.perr = pm[1] & bad_par;
        e.ferr = bad_stop;
        e.ovr  = 1'b0;
        return e;
    endfunction

    task automatic model_accept(input rx_entry_t e);
        logic addr;
        addr = e.data[8];
        if (mpc_en && !addr && !listen_m) return;
        if (mpc_en && addr) listen_m = (e.data[7:0] == own_addr);
        if (mq.size() == 2) mq[1].ovr = 1'b1;
        else mq.push_back(e);
    endtask

    task automatic put_bit(input logic b, input int glitch_at);
        for (int i = 0; i < BITLEN; i++) begin
            @(posedge clk);
            #1;
            rx_line = (i == glitch_at) ? ~b : b;
        end
    endtask

    task automatic send_frame(input logic [8:0] d, input logic bad_par,
                              input logic bad_stop, input int glitch_bit);
        int nb;
        logic [8:0] md;
        logic p;
        nb = int'(rx_bits);
        md = mask_bits(d, nb);
        put_bit(1'b0, -1);
        for (int k = 0; k < nb; k++) put_bit(md[k], (k == glitch_bit) ? 9 : -1);
        if (par_mode[1]) begin
            p = (^md) ^ par_mode[0] ^ bad_par;
            put_bit(p, -1);
        end
        put_bit(!bad_stop, -1);
        put_bit(1'b1, -1);
        if (bad_stop) put_bit(1'b1, -1);
        model_accept(expect_entry(d, nb, par_mode, bad_par, bad_stop));
    endtask

    task automatic pop_one();
        @(posedge clk);
        #1 rd_pop = 1'b1;
        @(posedge clk);
        #1 rd_pop = 1'b0;
    endtask

    task automatic drain(input string tag);
        rx_entry_t e;
        while (mq.size() > 0) begin
            e = mq.pop_front();
            @(negedge clk);
            chk({tag, " R7 avail"}, {11'd0, rx_avail}, 12'd1);
            chk(tag, {rd_bit9, rd_data, par_err, frm_err, ovr_err}, e);
            pop_one();
        end
        @(negedge clk);
        chk({tag, " R7 empty"}, {11'd0, rx_avail}, 12'd0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int nb, burst;
        logic [1:0] pm;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 reset", {8'd0, rx_avail, par_err, frm_err, ovr_err}, 12'd0);

        // R2 R7: two 8N1 frames, drained in order
        send_frame(9'h0A5, 0, 0, -1);
        send_frame(9'h03C, 0, 0, -1);
        drain("R2 8N1");

        // R2: 5 and 9 bit frames, upper bits masked
        rx_bits = 4'd5;
        send_frame(9'h1FF, 0, 0, -1);
        rx_bits = 4'd9;
        send_frame(9'h15A, 0, 0, -1);
        drain("R2 widths");

        // R3: single-tick glitch inside data bits
        rx_bits = 4'd8;
        send_frame(9'h0C3, 0, 0, 3);
        send_frame(9'h018, 0, 0, 0);
        drain("R3 glitch");

        // R4: short low pulse is no start bit
        @(posedge clk);
        #1 rx_line = 1'b0;
        repeat (3) @(posedge clk);
        #1 rx_line = 1'b1;
        repeat (3 * BITLEN) @(posedge clk);
        @(negedge clk);
        chk("R4 false start", {11'd0, rx_avail}, 12'd0);
        send_frame(9'h081, 0, 0, -1);
        drain("R4 after false start");

        // R5: parity good and bad, even and odd
        par_mode = 2'b10;
        send_frame(9'h0B7, 0, 0, -1);
        send_frame(9'h0B7, 1, 0, -1);
        drain("R5 even");
        par_mode = 2'b11;
        send_frame(9'h061, 0, 0, -1);
        send_frame(9'h061, 1, 0, -1);
        drain("R5 odd");
        par_mode = 2'b00;

        // R6: bad stop bit
        send_frame(9'h055, 0, 1, -1);
        send_frame(9'h0AA, 0, 0, -1);
        drain("R6 framing");

        // R8: third frame while full is lost
        send_frame(9'h011, 0, 0, -1);
        send_frame(9'h022, 0, 0, -1);
        send_frame(9'h033, 0, 0, -1);
        drain("R8 overrun");

        // R7: pop on empty buffer does nothing
        pop_one();
        @(negedge clk);
        chk("R7 empty pop", {11'd0, rx_avail}, 12'd0);

        // R9: address filtering
        rx_bits = 4'd9;
        mpc_en = 1'b1;
        send_frame(9'h077, 0, 0, -1);
        send_frame(9'h117, 0, 0, -1);
        send_frame(9'h078, 0, 0, -1);
        drain("R9 mismatch");
        send_frame(9'h142, 0, 0, -1);
        send_frame(9'h0E5, 0, 0, -1);
        drain("R9 match");
        mpc_en = 1'b0;

        // R10: disable flushes
        rx_bits = 4'd8;
        send_frame(9'h09C, 0, 0, -1);
        @(posedge clk);
        #1 rx_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 flush", {11'd0, rx_avail}, 12'd0);
        mq.delete();
        listen_m = 1'b0;
        @(posedge clk);
        #1 rx_en = 1'b1;
        send_frame(9'h04D, 0, 0, -1);
        drain("R10 after enable");

        // random frames in bursts, R2 R5 R6 R8
        for (int it = 0; it < 30; it++) begin
            burst = 1 + int'($urandom % 3);
            nb = 5 + int'($urandom % 5);
            case ($urandom % 3)
                0: pm = 2'b00;
                1: pm = 2'b10;
                default: pm = 2'b11;
            endcase
            rx_bits = 4'(nb);
            par_mode = pm;
            for (int f = 0; f < burst; f++)
                send_frame(9'($urandom), ($urandom % 6) == 0, ($urandom % 8) == 0, -1);
            drain("R2 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule